// File: doc/BRIEF.md
# GPIO bank interrupt controller

This block turns changes on a set of general-purpose input pins into one interrupt request. The pins are grouped into banks. Each bank has its own register set, and all banks share one simple memory-mapped write/read port. Each bank's register set sits at a fixed address stride from the next. For each pin, software picks level or edge sensitivity and a polarity. An edge pin can also be told to fire on both edges.

When a pin's selected condition occurs, its sticky pending bit is set. This happens whether or not the pin is enabled. Software turns pins on through a set-only enable register and off through a separate clear-only disable register. It can read back a mask register, which holds the inverse of the enable state. It drops pending bits by writing ones to the pending register.

The single interrupt output is registered. It is the OR, over every pin of every bank, of pending AND enabled. Each input passes through a two-flop synchronizer before detection, so an external change shows in the pending register three clock edges after it happens.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Writing the enable-set register (offset 0x04) enables every pin whose data bit is 1. Pins whose data bit is 0 keep their enable state.
- R2: Writing the disable register (offset 0x08) disables every pin whose data bit is 1. Pins whose data bit is 0 keep their enable state.
- R3: The mask register (offset 0x0C) reads 1 for a disabled pin and 0 for an enabled pin.
- R4: The pending register (offset 0x00) reads the sticky pending bits. Writing it clears each bit whose data is 1 and leaves the bits whose data is 0 unchanged.
- R5: In the type register (offset 0x10), a pin bit of 1 selects edge sensitivity. With the any-edge bit at 0, polarity 1 fires on a rising edge and polarity 0 fires on a falling edge. A change on an input sets its pending bit on the third rising clock edge after the change.
- R6: A pin bit of 1 in the any-edge register (offset 0x18) makes an edge pin fire on both edges, whatever its polarity bit (offset 0x14) holds.
- R7: A type bit of 0 selects level sensitivity. Polarity 1 means active-high and polarity 0 means active-low. While the active level stays, the pending bit is set again on every cycle, so a clear has no lasting effect.
- R8: If an edge event and a clear of the same pending bit fall in the same cycle, the bit stays set.
- R9: The interrupt output is registered. It is high one cycle after any pin is both pending and enabled, and low otherwise. Pending bits latch for disabled pins, and enabling such a pin later raises the interrupt.
- R10: Bank n's registers start at byte address n*0x40. An address in a bank slot that has no bank reads 0, and writes to it change nothing.
- R11: During and right after reset, the following hold:
  - every pin is disabled (the mask reads all ones);
  - the pending register reads 0;
  - the type, polarity and any-edge registers read 0;
  - the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W (8) | Byte address for both read and write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| pin_in | input | NUM_BANKS*PINS (64) | Asynchronous pin levels; bank n holds bits n*PINS and up |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is an edge event and a pending clear landing in the same cycle. The pin change enters through a two-flop synchronizer, so the bench changes the pin on a falling clock edge. It then raises the clear write exactly two falling edges later, which makes the clear strobe coincide with the detected edge.

The level-sensitive retrigger is reached in a similar way. A pin is held at its active level, a clear is issued, and the bit must reappear. The bench also steps through a table of sensitivity modes across both banks, covering each edge and polarity pairing and some cases with no event.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // Register offsets inside one bank slot (byte addresses)
   localparam int OFS_PEND  = 'h00;
   localparam int OFS_ENSET = 'h04;
   localparam int OFS_DIS   = 'h08;
   localparam int OFS_MASK  = 'h0C;
   localparam int OFS_TYPE  = 'h10;
   localparam int OFS_POL   = 'h14;
   localparam int OFS_BOTH  = 'h18;
   localparam int OFS_LAST  = OFS_BOTH + 4;

   typedef enum logic [1:0] {
      SENSE_LEVEL  = 2'd0,
      SENSE_SINGLE = 2'd1,
      SENSE_BOTH   = 2'd2
   } sense_e;

   function automatic sense_e sense_of(logic is_edge, logic both);
      if (!is_edge)  return SENSE_LEVEL;
      else if (both) return SENSE_BOTH;
      else           return SENSE_SINGLE;
   endfunction

   // One pin's event for this cycle
   function automatic logic pin_event(logic is_edge, logic pol, logic both,
                                      logic cur, logic prev);
      logic rise;
      logic fall;
      logic fire;
      rise = cur & ~prev;
      fall = ~cur & prev;
      case (sense_of(is_edge, both))
         SENSE_LEVEL:  fire = (cur == pol);
         SENSE_BOTH:   fire = rise | fall;
         default:      fire = pol ? rise : fall;
      endcase
      return fire;
   endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_irq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= raw_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int PINS = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] lvl,
   input  logic [PINS-1:0] cfg_edge,
   input  logic [PINS-1:0] cfg_pol,
   input  logic [PINS-1:0] cfg_both,
   output logic [PINS-1:0] hit
);

   logic [PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      assign hit[p] = gpio_irq_pkg::pin_event(cfg_edge[p], cfg_pol[p],
                                              cfg_both[p], lvl[p], prev_q[p]);
   end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_irq_pkg::*;
#(
   parameter int PINS        = 32,
   parameter int DATA_W      = 32,
   parameter int OFS_W       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_we,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PINS-1:0]   pin_raw,
   output logic [DATA_W-1:0] rdata,
   output logic [PINS-1:0]   pend,
   output logic [PINS-1:0]   enab,
   output logic              req
);

   localparam logic [OFS_W-1:0] A_PEND  = OFS_W'(OFS_PEND);
   localparam logic [OFS_W-1:0] A_ENSET = OFS_W'(OFS_ENSET);
   localparam logic [OFS_W-1:0] A_DIS   = OFS_W'(OFS_DIS);
   localparam logic [OFS_W-1:0] A_MASK  = OFS_W'(OFS_MASK);
   localparam logic [OFS_W-1:0] A_TYPE  = OFS_W'(OFS_TYPE);
   localparam logic [OFS_W-1:0] A_POL   = OFS_W'(OFS_POL);
   localparam logic [OFS_W-1:0] A_BOTH  = OFS_W'(OFS_BOTH);

   logic [PINS-1:0] en_q, pend_q, type_q, pol_q, both_q;
   logic [PINS-1:0] lvl, hit, clr, wbits;

   assign wbits = wdata[PINS-1:0];

   gpio_irq_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (pin_raw),
      .sync_out (lvl)
   );

   gpio_irq_detect #(.PINS(PINS)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl),
      .cfg_edge (type_q),
      .cfg_pol  (pol_q),
      .cfg_both (both_q),
      .hit      (hit)
   );

   assign clr = (sel_we && ofs == A_PEND) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pend_q <= '0;
         type_q <= '0;
         pol_q  <= '0;
         both_q <= '0;
      end else begin
         // a new event in the same cycle overrides a clear
         pend_q <= (pend_q & ~clr) | hit;
         if (sel_we) begin
            case (ofs)
               A_ENSET: en_q   <= en_q | wbits;
               A_DIS:   en_q   <= en_q & ~wbits;
               A_TYPE:  type_q <= wbits;
               A_POL:   pol_q  <= wbits;
               A_BOTH:  both_q <= wbits;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (ofs)
         A_PEND:  rdata = DATA_W'(pend_q);
         A_MASK:  rdata = DATA_W'(~en_q);
         A_TYPE:  rdata = DATA_W'(type_q);
         A_POL:   rdata = DATA_W'(pol_q);
         A_BOTH:  rdata = DATA_W'(both_q);
         default: rdata = '0;
      endcase
   end

   assign pend = pend_q;
   assign enab = en_q;
   assign req  = |(pend_q & en_q);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NUM_BANKS   = 2,
   parameter int PINS        = 32,
   parameter int DATA_W      = 32,
   parameter int BANK_STRIDE = 'h40,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_we,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [DATA_W-1:0]         bus_rdata,
   input  logic [NUM_BANKS*PINS-1:0] pin_in,
   output logic                      irq_out
);

   localparam int OFS_W  = $clog2(BANK_STRIDE);
   localparam int BIDX_W = ADDR_W - OFS_W;
   localparam int TOTAL  = NUM_BANKS * PINS;

   if (PINS < 1 || PINS > DATA_W) begin : g_bad_pins
      $error("gpio_irq_ctrl: PINS must be 1..DATA_W");
   end
   if ((1 << OFS_W) != BANK_STRIDE || BANK_STRIDE < OFS_LAST) begin : g_bad_stride
      $error("gpio_irq_ctrl: BANK_STRIDE must be a power of two covering all registers");
   end
   if (BIDX_W < 1 || (1 << BIDX_W) < NUM_BANKS) begin : g_bad_addr
      $error("gpio_irq_ctrl: ADDR_W too small for NUM_BANKS");
   end

   logic [OFS_W-1:0]  ofs;
   logic [BIDX_W-1:0] bidx;
   logic [DATA_W-1:0] rd_bank [NUM_BANKS];
   logic [NUM_BANKS-1:0] req_bank;
   logic [TOTAL-1:0]  pend_all;
   logic [TOTAL-1:0]  enab_all;
   logic              irq_q;

   assign ofs  = bus_addr[OFS_W-1:0];
   assign bidx = bus_addr[ADDR_W-1:OFS_W];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = bus_we && (bidx == BIDX_W'(b));

      gpio_irq_bank #(
         .PINS(PINS), .DATA_W(DATA_W), .OFS_W(OFS_W), .SYNC_STAGES(SYNC_STAGES)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel_we  (sel),
         .ofs     (ofs),
         .wdata   (bus_wdata),
         .pin_raw (pin_in[b*PINS +: PINS]),
         .rdata   (rd_bank[b]),
         .pend    (pend_all[b*PINS +: PINS]),
         .enab    (enab_all[b*PINS +: PINS]),
         .req     (req_bank[b])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bidx == BIDX_W'(b)) bus_rdata = rd_bank[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |req_bank;
   end

   assign irq_out = irq_q;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
   import gpio_irq_pkg::*;
#(
   parameter int TOTAL  = 64,
   parameter int PINS   = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int OFS_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [TOTAL-1:0]  pend_all,
   input logic [TOTAL-1:0]  enab_all,
   input logic              irq_out
);

   // R1
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OFS_ENSET)) |=>
      ((enab_all[PINS-1:0] & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0])));

   // R2
   dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OFS_DIS)) |=>
      ((enab_all[PINS-1:0] & $past(bus_wdata[PINS-1:0])) == '0));

   // R3
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(enab_all));

   // R4
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr[OFS_W-1:0] == OFS_W'(OFS_PEND)) |=>
      (($past(pend_all) & ~pend_all) == '0));

   // R9
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_all & enab_all)) |=> irq_out);

   // R9
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(|(pend_all & enab_all)));

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(
   .TOTAL(TOTAL), .PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pend_all  (pend_all),
   .enab_all  (enab_all),
   .irq_out   (irq_out)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;

   localparam int NB = 2;
   localparam int P  = 32;
   localparam int AW = 8;
   localparam int STRIDE = 'h40;
   localparam int A_PEND = 'h00, A_ENSET = 'h04, A_DIS = 'h08, A_MASK = 'h0C;
   localparam int A_TYPE = 'h10, A_POL = 'h14, A_BOTH = 'h18;

   // {edge, pol, both, start, finish, expect}
   localparam logic [5:0] VEC [10] = '{
      6'b110_01_1, 6'b110_10_0, 6'b100_10_1, 6'b100_01_0,
      6'b101_01_1, 6'b111_10_1, 6'b101_11_0,
      6'b010_01_1, 6'b000_10_1, 6'b010_00_0 };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NB*P-1:0] pin_in = '0;
   logic irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   gpio_irq_ctrl #(.NUM_BANKS(NB), .PINS(P), .DATA_W(32),
                   .BANK_STRIDE(STRIDE), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .irq_out(irq_out));

   task automatic nb(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int addr, logic [31:0] d);
      bus_addr = AW'(addr); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(int addr, output logic [31:0] d);
      bus_addr = AW'(addr);
      #1 d = bus_rdata;
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      logic [31:0] d;
      // R11 reset state, read while reset is held
      nb(2);
      rd(A_MASK, d);  chk("R11 mask at reset", d, 32'hFFFF_FFFF);
      rd(A_PEND, d);  chk("R11 pending at reset", d, 32'h0);
      rd(A_TYPE, d);  chk("R11 type at reset", d, 32'h0);
      rd(STRIDE + A_POL, d);  chk("R11 polarity at reset", d, 32'h0);
      rd(STRIDE + A_BOTH, d); chk("R11 any-edge at reset", d, 32'h0);
      chk("R11 irq at reset", {31'b0, irq_out}, 32'h0);
      rst_n = 1'b1;
      nb(2);

      // table of sensitivity modes (R5 R6 R7)
      for (int i = 0; i < 10; i++) begin
         int b;
         int pin;
         int base;
         logic [5:0] v;
         v = VEC[i];
         b = i % NB;
         pin = (i * 7) % P;
         base = b * STRIDE;
         pin_in[b*P + pin] = v[2];
         nb(5);
         wr(base + A_TYPE, {32{v[5]}});
         wr(base + A_POL,  {32{v[4]}});
         wr(base + A_BOTH, {32{v[3]}});
         nb(4);
         wr(base + A_PEND, 32'hFFFF_FFFF);
         pin_in[b*P + pin] = v[1];
         nb(4);
         rd(base + A_PEND, d);
         if (!v[5])
            chk($sformatf("R7 level vec %0d", i), {31'b0, d[pin]}, {31'b0, v[0]});
         else if (v[3])
            chk($sformatf("R6 any-edge vec %0d", i), {31'b0, d[pin]}, {31'b0, v[0]});
         else
            chk($sformatf("R5 single-edge vec %0d", i), {31'b0, d[pin]}, {31'b0, v[0]});
      end

      // bank 0 rising-edge on all pins, all pins low, clean state
      pin_in = '0;
      wr(A_TYPE, 32'hFFFF_FFFF);
      wr(A_POL, 32'hFFFF_FFFF);
      wr(A_BOTH, 32'h0);
      nb(5);
      wr(A_PEND, 32'hFFFF_FFFF);
      wr(STRIDE + A_PEND, 32'hFFFF_FFFF);
      rd(A_PEND, d); chk("R4 clear all", d, 32'h0);
      rd(A_TYPE, d); chk("R5 type readback", d, 32'hFFFF_FFFF);

      // R1 R2 R3 enable/disable/mask
      wr(A_ENSET, 32'h0000_00F0);
      rd(A_MASK, d); chk("R1 enable set first", d, ~32'h0000_00F0);
      wr(A_ENSET, 32'h0000_0003);
      rd(A_MASK, d); chk("R1 enable set keeps others", d, ~32'h0000_00F3);
      wr(A_DIS, 32'h0000_0010);
      rd(A_MASK, d); chk("R2 disable keeps others", d, ~32'h0000_00E3);
      wr(A_DIS, 32'h0);
      rd(A_MASK, d); chk("R3 zero disable no change", d, ~32'h0000_00E3);

      // R5 latency and R9 interrupt timing on enabled pin 1
      chk("R9 irq idle", {31'b0, irq_out}, 32'h0);
      pin_in[1] = 1'b1;
      nb(2);
      rd(A_PEND, d); chk("R5 not yet pending after two edges", d, 32'h0);
      nb(1);
      rd(A_PEND, d); chk("R5 pending on third edge", d, 32'h0000_0002);
      chk("R9 irq one cycle behind", {31'b0, irq_out}, 32'h0);
      nb(1);
      chk("R9 irq raised", {31'b0, irq_out}, 32'h1);

      // R9 disabled pin latches but does not interrupt
      pin_in[8] = 1'b1;
      nb(4);
      wr(A_PEND, 32'h0000_0002);
      rd(A_PEND, d); chk("R4 selective clear", d, 32'h0000_0100);
      nb(1);
      chk("R9 disabled pending gives no irq", {31'b0, irq_out}, 32'h0);
      wr(A_ENSET, 32'h0000_0100);
      nb(1);
      chk("R9 enable of latched pin raises irq", {31'b0, irq_out}, 32'h1);
      wr(A_DIS, 32'h0000_0100);
      nb(1);
      chk("R9 disable drops irq", {31'b0, irq_out}, 32'h0);

      // R8 event and clear in the same cycle
      pin_in[9] = 1'b1;
      nb(2);
      wr(A_PEND, 32'h0000_0200);
      nb(1);
      rd(A_PEND, d); chk("R8 event wins over clear", d, 32'h0000_0300);
      wr(A_PEND, 32'h0000_0200);
      rd(A_PEND, d); chk("R4 clear with no event", d, 32'h0000_0100);

      // R7 level-high retrigger after clear
      wr(A_TYPE, 32'h0);
      nb(3);
      wr(A_PEND, 32'hFFFF_FFFF);
      nb(2);
      rd(A_PEND, d); chk("R7 active level re-sets after clear", d, 32'h0000_0302);
      pin_in[9] = 1'b0;
      nb(4);
      wr(A_PEND, 32'hFFFF_FFFF);
      nb(2);
      rd(A_PEND, d); chk("R7 inactive pin stays cleared", d, 32'h0000_0102);

      // R10 bank stride and empty slot
      wr(STRIDE + A_TYPE, 32'hFFFF_FFFF);
      wr(STRIDE + A_POL, 32'hFFFF_FFFF);
      wr(STRIDE + A_BOTH, 32'h0);
      nb(4);
      wr(STRIDE + A_PEND, 32'hFFFF_FFFF);
      pin_in[P + 5] = 1'b1;
      nb(4);
      rd(STRIDE + A_PEND, d); chk("R10 bank 1 event", d, 32'h0000_0020);
      rd(A_PEND, d); chk("R10 bank 0 untouched", d, 32'h0000_0102);
      wr(2*STRIDE + A_TYPE, 32'h1234_5678);
      rd(2*STRIDE + A_TYPE, d); chk("R10 empty slot reads zero", d, 32'h0);
      rd(A_TYPE, d); chk("R10 empty slot write ignored", d, 32'h0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule